// File: doc/BRIEF.md
# Capture/Compare Event Timer

This block is a 16-bit up-counter with a selectable prescaler and capture and compare logic around it. The counter counts a machine-cycle tick or rising edges on an external count pin, after division by 1, 2, 4 or 8. Software cannot load the counter. It returns to zero on reset, on an enabled rising edge of an external clear pin, and while an idle input is held high.

Four capture channels copy the counter into their own registers on a chosen edge of their pins. The pins are sampled once per machine cycle. Three compare registers act on an 8-bit event port. One match drives the six low bits high and a second match drives them low, each bit through its own enable mask. A third match flips the two high bits. Flags for capture, compare, low-byte wrap and full wrap stay set until software clears them. The two wrap flags can each be enabled onto a shared overflow request.

Software reaches the block through a simple register port with one-cycle writes and combinational reads. Register addresses: 0 control, 1 capture modes, 2 to 4 compare 0 to 2, 5 set mask, 6 clear mask, 7 toggle mask, 8 port data, 9 flags, 10 counter (read only).

Top module: `cc_event_timer`

## Requirements
- R1: Control bits [1:0] select prescaler division 1, 2, 4 or 8 (codes 0 to 3). The counter advances once per that many source events.
- R2: Control bits [3:2] select the count source: 1 is the tick input, 2 is rising edges of the count pin, and 0 or 3 is off. While off the counter holds.
- R3: The prescaler returns to zero when a control write changes bits [3:0], and whenever the counter is cleared.
- R4: A write to the counter address has no effect. The counter is zero after reset, and it is cleared on a rising edge of the clear pin when control bit 4 is set. With bit 4 clear, that edge is ignored.
- R5: Capture-mode bits [2k] (rising) and [2k+1] (falling) select the edges of channel k. A selected edge copies the counter value from before that clock edge into the channel register and sets flag bit k. With both mode bits zero, nothing is captured and no flag is set.
- R6: Capture pins are sampled only on tick cycles. An edge is seen when the sample taken at one tick differs from the sample taken at the previous tick.
- R7: A compare match fires once, in the cycle after the counter changes to the value of compare k, and sets flag bit 4+k. The port action follows one clock later.
- R8: A compare 0 match drives port bit i (i = 0 to 5) high where set-mask bit i is 1. A compare 1 match drives it low where clear-mask bit i is 1. When both match together, the clear wins.
- R9: A compare 2 match inverts port bit 6 when toggle-mask bit 0 is 1, and port bit 7 when toggle-mask bit 1 is 1.
- R10: A wrap of the low byte sets flag bit 7, and a wrap of all 16 bits sets flag bit 8. The overflow request is (bit7 AND control bit 5) OR (bit8 AND control bit 6).
- R11: A software port write that lands in the same cycle as a compare action keeps the written value on the unaffected bits. The compare action still applies to its own bits.
- R12: Flags clear only when a 1 is written to their bit at the flags address. Writing 0 leaves them unchanged. A new event in the clearing cycle keeps the flag set.
- R13: While idle is high, the counter and the prescaler are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| cnt_pin_i | input | 1 | External count pin |
| ext_rst_pin_i | input | 1 | External counter-clear pin |
| idle_i | input | 1 | Idle request; holds counter and prescaler at zero |
| cap_pin_i | input | 4 | Capture pins, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data (combinational) |
| cap_val_o | output | 64 | Capture registers; channel k at bits [16k+15:16k] |
| port_o | output | 8 | Event port |
| cap_flag_o | output | 4 | Capture flags |
| cmp_flag_o | output | 3 | Compare flags |
| ovf_lo_flag_o | output | 1 | Low-byte wrap flag |
| ovf_hi_flag_o | output | 1 | 16-bit wrap flag |
| ovf_irq_o | output | 1 | Shared overflow request |

## Verification
The count path is driven by tick bursts at each division factor and by count-pin pulses. It is also driven with the source off, with an odd prescaler phase when the division factor changes, and under idle, which separates division errors from missing prescaler clears. The capture channels get pin changes with no tick and a rising and a falling edge on all four channels at once, each channel set to a different edge mode. This shows edge selection and sampling per channel. The compare port is driven with separate matches, with a set and a clear that match in the same cycle, with a port write in the match cycle, and with seeded random compare values against random tick counts. Together these show once-only firing and toggle parity. Full runs of 256 and 65536 ticks check both wrap flags and the gating of the overflow request.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_CAPM  = 4'd1,
    A_CMP0  = 4'd2,
    A_CMP1  = 4'd3,
    A_CMP2  = 4'd4,
    A_SETEN = 4'd5,
    A_RSTEN = 4'd6,
    A_TGLEN = 4'd7,
    A_PORT  = 4'd8,
    A_FLAGS = 4'd9,
    A_COUNT = 4'd10
  } cct_addr_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_TICK = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_OFF2 = 2'd3
  } cct_src_e;

  localparam int CTRL_W     = 7;
  localparam int CTRL_XRST  = 4;
  localparam int CTRL_IRQLO = 5;
  localparam int CTRL_IRQHI = 6;
  localparam int NCMP       = 3;
endpackage

// File: rtl/cct_count.sv
`timescale 1ns/1ps
module cct_count
  import cct_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LO_W      = 8,
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 cnt_pin_i,
  input  logic                 ext_rst_pin_i,
  input  logic                 ext_rst_en_i,
  input  logic                 idle_i,
  input  logic [DIV_SEL_W-1:0] div_i,
  input  cct_src_e             src_i,
  input  logic                 cfg_chg_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 step_o,
  output logic                 ovf_lo_o,
  output logic                 ovf_hi_o
);
  localparam int PRE_W = (1 << DIV_SEL_W) - 1;

  logic             pin_s1_q, pin_s2_q, clr_s1_q, clr_s2_q;
  logic [PRE_W-1:0] pre_q, pre_d, pre_last;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_q, step_d;
  logic             src_ev, pre_wrap, inc, cnt_clr, pre_en, cnt_en;

  // source event and prescaler terminal value
  always_comb begin
    unique case (src_i)
      SRC_TICK: src_ev = tick_i;
      SRC_PIN:  src_ev = pin_s1_q & ~pin_s2_q;
      default:  src_ev = 1'b0;
    endcase
    pre_last = PRE_W'((1 << div_i) - 1);
    pre_wrap = (pre_q == pre_last);
    cnt_clr  = idle_i | (ext_rst_en_i & clr_s1_q & ~clr_s2_q);
    inc      = src_ev & pre_wrap & ~cnt_clr;
  end

  always_comb begin
    pre_en = cnt_clr | cfg_chg_i | src_ev;
    if (cnt_clr || cfg_chg_i) pre_d = '0;
    else if (pre_wrap)        pre_d = '0;
    else                      pre_d = pre_q + 1'b1;

    cnt_en = cnt_clr | inc;
    if (cnt_clr) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;

    step_d = cnt_en && (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1_q <= 1'b0;
      pin_s2_q <= 1'b0;
      clr_s1_q <= 1'b0;
      clr_s2_q <= 1'b0;
      pre_q    <= '0;
      cnt_q    <= '0;
      step_q   <= 1'b0;
    end else begin
      pin_s1_q <= cnt_pin_i;
      pin_s2_q <= pin_s1_q;
      clr_s1_q <= ext_rst_pin_i;
      clr_s2_q <= clr_s1_q;
      step_q   <= step_d;
      if (pre_en) pre_q <= pre_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign step_o   = step_q;
  assign ovf_lo_o = inc & (&cnt_q[LO_W-1:0]);
  assign ovf_hi_o = inc & (&cnt_q);

  // R13: idle leaves counter and prescaler at zero
  a_r13_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (cnt_q == '0 && pre_q == '0));

  // R3: changing division or source restarts the prescaler
  a_r3_cfg_restarts_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg_i |=> (pre_q == '0));

  // R4: counter only steps by one or returns to zero
  a_r4_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: rtl/cct_capture.sv
`timescale 1ns/1ps
module cct_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             hit_o
);
  logic             samp_q;
  logic [CNT_W-1:0] val_q;
  logic             rise, fall, hit;

  always_comb begin
    rise = tick_i &  pin_i & ~samp_q;
    fall = tick_i & ~pin_i &  samp_q;
    hit  = (rise & mode_i[0]) | (fall & mode_i[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      val_q  <= '0;
    end else begin
      if (tick_i) samp_q <= pin_i;
      if (hit)    val_q  <= cnt_i;
    end
  end

  assign val_o = val_q;
  assign hit_o = hit;

  // R5: with no edge selected the register keeps its value
  a_r5_no_mode_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> $stable(val_q));

  // R6: nothing is captured outside tick cycles
  a_r6_capture_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(val_q));
endmodule

// File: rtl/cct_cmp_port.sv
`timescale 1ns/1ps
module cct_cmp_port
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PORT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic                       step_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  input  logic [PORT_W-3:0]          set_en_i,
  input  logic [PORT_W-3:0]          rst_en_i,
  input  logic [1:0]                 tgl_en_i,
  input  logic                       port_wr_i,
  input  logic [PORT_W-1:0]          port_wdata_i,
  output logic [PORT_W-1:0]          port_o,
  output logic [NCMP-1:0]            match_o
);
  localparam int NSET = PORT_W - 2;
  localparam int NTGL = 2;

  logic [NCMP-1:0]   match;
  logic [PORT_W-1:0] port_q, port_d;
  logic              port_en;

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    assign match[k] = step_i && (cnt_i == cmp_i[k]);
  end

  always_comb begin
    port_d = port_wr_i ? port_wdata_i : port_q;
    for (int i = 0; i < NSET; i++) begin
      if (match[0] && set_en_i[i]) port_d[i] = 1'b1;
      if (match[1] && rst_en_i[i]) port_d[i] = 1'b0;
    end
    for (int j = 0; j < NTGL; j++) begin
      if (match[2] && tgl_en_i[j]) port_d[NSET+j] = ~port_d[NSET+j];
    end
    port_en = port_wr_i | (|match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (port_en) port_q <= port_d;
  end

  assign port_o  = port_q;
  assign match_o = match;

  // R8: coincident set and clear leaves the cleared bits low
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (match[0] && match[1]) |=> ((port_q[NSET-1:0] & $past(rst_en_i)) == '0));

  // R7: a match never repeats on the following cycle
  a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |=> ((match & $past(match)) == '0));

  // R9: enabled toggle flips bit NSET
  a_r9_toggle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (match[2] && !port_wr_i && tgl_en_i[0]) |=> (port_q[NSET] != $past(port_q[NSET])));
endmodule

// File: rtl/cc_event_timer.sv
`timescale 1ns/1ps
module cc_event_timer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCAP   = 4,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  cnt_pin_i,
  input  logic                  ext_rst_pin_i,
  input  logic                  idle_i,
  input  logic [NCAP-1:0]       cap_pin_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic [CNT_W-1:0]      rd_data_o,
  output logic [NCAP*CNT_W-1:0] cap_val_o,
  output logic [PORT_W-1:0]     port_o,
  output logic [NCAP-1:0]       cap_flag_o,
  output logic [NCMP-1:0]       cmp_flag_o,
  output logic                  ovf_lo_flag_o,
  output logic                  ovf_hi_flag_o,
  output logic                  ovf_irq_o
);
  localparam int NSET   = PORT_W - 2;
  localparam int CAPM_W = 2 * NCAP;
  localparam int FL_W   = NCAP + NCMP + 2;
  localparam int FL_LO  = NCAP + NCMP;
  localparam int FL_HI  = NCAP + NCMP + 1;

  logic [CTRL_W-1:0]            ctrl_q;
  logic [CAPM_W-1:0]            capm_q;
  logic [NCMP-1:0][CNT_W-1:0]   cmp_q;
  logic [NSET-1:0]              seten_q, rsten_q;
  logic [1:0]                   tglen_q;
  logic [FL_W-1:0]              flags_q, flags_d, flags_set, flags_clr;

  logic wr_ctrl, wr_capm, wr_seten, wr_rsten, wr_tglen, wr_port, wr_flags;
  logic [NCMP-1:0] wr_cmp;
  logic cfg_chg;

  logic [CNT_W-1:0]  cnt;
  logic              step, ovf_lo, ovf_hi;
  logic [NCAP-1:0]   cap_hit;
  logic [NCMP-1:0]   match;
  logic [PORT_W-1:0] port;

  // write decode
  always_comb begin
    wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
    wr_capm  = wr_en_i && (addr_i == A_CAPM);
    wr_seten = wr_en_i && (addr_i == A_SETEN);
    wr_rsten = wr_en_i && (addr_i == A_RSTEN);
    wr_tglen = wr_en_i && (addr_i == A_TGLEN);
    wr_port  = wr_en_i && (addr_i == A_PORT);
    wr_flags = wr_en_i && (addr_i == A_FLAGS);
    for (int k = 0; k < NCMP; k++) begin
      wr_cmp[k] = wr_en_i && (addr_i == ADDR_W'(A_CMP0) + ADDR_W'(k));
    end
    cfg_chg = wr_ctrl && (wr_data_i[3:0] != ctrl_q[3:0]);
  end

  // config registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      capm_q  <= '0;
      cmp_q   <= '0;
      seten_q <= '0;
      rsten_q <= '0;
      tglen_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wr_data_i[CTRL_W-1:0];
      if (wr_capm)  capm_q  <= wr_data_i[CAPM_W-1:0];
      if (wr_seten) seten_q <= wr_data_i[NSET-1:0];
      if (wr_rsten) rsten_q <= wr_data_i[NSET-1:0];
      if (wr_tglen) tglen_q <= wr_data_i[1:0];
      for (int k = 0; k < NCMP; k++) begin
        if (wr_cmp[k]) cmp_q[k] <= wr_data_i;
      end
    end
  end

  cct_count #(.CNT_W(CNT_W), .LO_W(8), .DIV_SEL_W(2)) u_count (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .cnt_pin_i     (cnt_pin_i),
    .ext_rst_pin_i (ext_rst_pin_i),
    .ext_rst_en_i  (ctrl_q[CTRL_XRST]),
    .idle_i        (idle_i),
    .div_i         (ctrl_q[1:0]),
    .src_i         (cct_src_e'(ctrl_q[3:2])),
    .cfg_chg_i     (cfg_chg),
    .cnt_o         (cnt),
    .step_o        (step),
    .ovf_lo_o      (ovf_lo),
    .ovf_hi_o      (ovf_hi)
  );

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    cct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .pin_i  (cap_pin_i[k]),
      .mode_i (capm_q[2*k +: 2]),
      .cnt_i  (cnt),
      .val_o  (cap_val_o[k*CNT_W +: CNT_W]),
      .hit_o  (cap_hit[k])
    );
  end

  cct_cmp_port #(.CNT_W(CNT_W), .PORT_W(PORT_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt),
    .step_i       (step),
    .cmp_i        (cmp_q),
    .set_en_i     (seten_q),
    .rst_en_i     (rsten_q),
    .tgl_en_i     (tglen_q),
    .port_wr_i    (wr_port),
    .port_wdata_i (wr_data_i[PORT_W-1:0]),
    .port_o       (port),
    .match_o      (match)
  );

  // interrupt flags: write one to clear, set wins
  always_comb begin
    flags_set = {ovf_hi, ovf_lo, match, cap_hit};
    flags_clr = wr_flags ? wr_data_i[FL_W-1:0] : '0;
    flags_d   = (flags_q & ~flags_clr) | flags_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // register read
  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      A_CTRL:  rd_data_o = CNT_W'(ctrl_q);
      A_CAPM:  rd_data_o = CNT_W'(capm_q);
      A_CMP0:  rd_data_o = cmp_q[0];
      A_CMP1:  rd_data_o = cmp_q[1];
      A_CMP2:  rd_data_o = cmp_q[2];
      A_SETEN: rd_data_o = CNT_W'(seten_q);
      A_RSTEN: rd_data_o = CNT_W'(rsten_q);
      A_TGLEN: rd_data_o = CNT_W'(tglen_q);
      A_PORT:  rd_data_o = CNT_W'(port);
      A_FLAGS: rd_data_o = CNT_W'(flags_q);
      A_COUNT: rd_data_o = cnt;
      default: rd_data_o = '0;
    endcase
  end

  assign port_o        = port;
  assign cap_flag_o    = flags_q[NCAP-1:0];
  assign cmp_flag_o    = flags_q[NCAP +: NCMP];
  assign ovf_lo_flag_o = flags_q[FL_LO];
  assign ovf_hi_flag_o = flags_q[FL_HI];
  assign ovf_irq_o     = (flags_q[FL_LO] & ctrl_q[CTRL_IRQLO]) |
                         (flags_q[FL_HI] & ctrl_q[CTRL_IRQHI]);

  // R12: a flag stays set unless a one is written to its bit
  a_r12_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~flags_clr)) == $past(flags_q & ~flags_clr)));

  // R10: overflow request only from a set and enabled wrap flag
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> (ovf_lo_flag_o || ovf_hi_flag_o));
endmodule

// File: tb/cc_event_timer_tb_top.sv
`timescale 1ns/1ps
module cc_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, cnt_pin_i, ext_rst_pin_i, idle_i;
  logic [3:0]  cap_pin_i;
  logic        wr_en_i;
  logic [3:0]  addr_i;
  logic [15:0] wr_data_i;
  logic [15:0] rd_data_o;
  logic [63:0] cap_val_o;
  logic [7:0]  port_o;
  logic [3:0]  cap_flag_o;
  logic [2:0]  cmp_flag_o;
  logic        ovf_lo_flag_o, ovf_hi_flag_o, ovf_irq_o;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] A_CTRL = 0, A_CAPM = 1, A_CMP0 = 2, A_CMP1 = 3, A_CMP2 = 4,
                         A_SETEN = 5, A_RSTEN = 6, A_TGLEN = 7, A_PORT = 8,
                         A_FLAGS = 9, A_COUNT = 10;

  always #2 clk = ~clk;

  cc_event_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .ext_rst_pin_i(ext_rst_pin_i), .idle_i(idle_i), .cap_pin_i(cap_pin_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .cap_val_o(cap_val_o), .port_o(port_o), .cap_flag_o(cap_flag_o),
    .cmp_flag_o(cmp_flag_o), .ovf_lo_flag_o(ovf_lo_flag_o),
    .ovf_hi_flag_o(ovf_hi_flag_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr_i = a;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step();
      tick_i = 1'b0; step();
    end
  endtask

  task automatic pulse_clr();
    ext_rst_pin_i = 1'b1; step();
    ext_rst_pin_i = 1'b0; step();
    step(); step(); step();
  endtask

  function automatic logic [7:0] exp_toggle(input logic [7:0] p, input int n, input int v);
    return (n >= v) ? (p ^ 8'h40) : p;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  p0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; tick_i = 0; cnt_pin_i = 0; ext_rst_pin_i = 0; idle_i = 0;
    cap_pin_i = 0; wr_en_i = 0; addr_i = 0; wr_data_i = 0;
    step(); step(); step();
    rst_n = 1'b1; step();

    // reset state (R4)
    rd(A_COUNT, v); chk("R4 reset count", v, 0);
    chk("R4 reset port", port_o, 0);
    rd(A_FLAGS, v); chk("R12 reset flags", v, 0);
    chk("R5 reset capture", cap_val_o, 0);

    // source off (R2)
    wr(A_CTRL, 16'h0000); ticks(5);
    rd(A_COUNT, v); chk("R2 src off", v, 0);
    wr(A_CTRL, 16'h000C); ticks(5);
    rd(A_COUNT, v); chk("R2 src code 3 off", v, 0);

    // divide by 1 and 4 (R1)
    wr(A_CTRL, 16'h0004); ticks(10);
    rd(A_COUNT, v); chk("R1 div1", v, 10);
    wr(A_CTRL, 16'h0006); ticks(8);
    rd(A_COUNT, v); chk("R1 div4 eight ticks", v, 12);
    ticks(3);
    rd(A_COUNT, v); chk("R1 div4 partial", v, 12);
    ticks(1);
    rd(A_COUNT, v); chk("R1 div4 terminal", v, 13);

    // prescaler restart on config change (R3)
    wr(A_CTRL, 16'h0007); ticks(5);
    rd(A_COUNT, v); chk("R3 div8 partial", v, 13);
    wr(A_CTRL, 16'h0006); ticks(3);
    rd(A_COUNT, v); chk("R3 restarted prescaler holds", v, 13);
    ticks(1);
    rd(A_COUNT, v); chk("R3 restarted prescaler counts", v, 14);

    // count pin source (R2)
    wr(A_CTRL, 16'h0008);
    for (int i = 0; i < 6; i++) begin
      cnt_pin_i = 1'b1; step(); cnt_pin_i = 1'b0; step();
    end
    step(); step(); step();
    rd(A_COUNT, v); chk("R2 pin edges", v, 20);
    ticks(4);
    rd(A_COUNT, v); chk("R2 tick ignored on pin source", v, 20);

    // external clear and no load (R4)
    pulse_clr();
    rd(A_COUNT, v); chk("R4 clear disabled", v, 20);
    wr(A_CTRL, 16'h0018); pulse_clr();
    rd(A_COUNT, v); chk("R4 clear enabled", v, 0);
    wr(A_COUNT, 16'h1234); step();
    rd(A_COUNT, v); chk("R4 count not writable", v, 0);

    // idle (R13)
    wr(A_CTRL, 16'h0014); ticks(7);
    rd(A_COUNT, v); chk("R13 before idle", v, 7);
    idle_i = 1'b1; step(); ticks(5);
    rd(A_COUNT, v); chk("R13 idle holds zero", v, 0);
    idle_i = 1'b0; ticks(3);
    rd(A_COUNT, v); chk("R13 counts after idle", v, 3);

    // capture (R5, R6)
    wr(A_FLAGS, 16'h01FF);
    wr(A_CAPM, 16'h0039);
    cap_pin_i = 4'hF; step(); step(); step();
    chk("R6 no capture without tick", cap_flag_o, 0);
    ticks(1);
    chk("R5 rising flags", cap_flag_o, 4'b0101);
    chk("R5 ch0 rising value", cap_val_o[15:0], 3);
    chk("R5 ch2 both value", cap_val_o[47:32], 3);
    cap_pin_i = 4'h0; step(); step();
    ticks(1);
    chk("R5 falling flags", cap_flag_o, 4'b0111);
    chk("R5 ch1 falling value", cap_val_o[31:16], 4);
    chk("R5 ch2 falling value", cap_val_o[47:32], 4);
    chk("R5 ch0 keeps value", cap_val_o[15:0], 3);
    chk("R5 ch3 none value", cap_val_o[63:48], 0);

    // compare actions (R7, R8, R9)
    pulse_clr();
    wr(A_SETEN, 16'h003F); wr(A_RSTEN, 16'h000F); wr(A_TGLEN, 16'h0003);
    wr(A_CMP0, 16'd5); wr(A_CMP1, 16'd8); wr(A_CMP2, 16'd3);
    wr(A_PORT, 16'h0000); wr(A_FLAGS, 16'h01FF);
    ticks(3);
    chk("R9 toggle both high bits", port_o, 8'hC0);
    chk("R7 compare 2 flag", cmp_flag_o, 3'b100);
    step(); step(); step(); step(); step();
    chk("R7 match fires once", port_o, 8'hC0);
    ticks(2);
    chk("R8 set bits", port_o, 8'hFF);
    ticks(3);
    chk("R8 clear masked bits", port_o, 8'hF0);
    chk("R7 all compare flags", cmp_flag_o, 3'b111);
    ticks(4);
    rd(A_PORT, v); chk("R7 no repeat after passing", v, 16'h00F0);

    // coincident set and clear (R8)
    wr(A_RSTEN, 16'h003F); wr(A_CMP0, 16'd20); wr(A_CMP1, 16'd20);
    wr(A_PORT, 16'h002A);
    ticks(8);
    chk("R8 clear wins", port_o, 8'h00);

    // write in match cycle (R11)
    wr(A_SETEN, 16'h0003); wr(A_RSTEN, 16'h0000); wr(A_CMP0, 16'd30);
    ticks(9);
    tick_i = 1'b1; step(); tick_i = 1'b0;
    wr(A_PORT, 16'h0080); step();
    chk("R11 write merged with set", port_o, 8'h83);

    // overflow (R10, R12)
    wr(A_SETEN, 0); wr(A_TGLEN, 0);
    wr(A_CTRL, 16'h0034); pulse_clr(); wr(A_FLAGS, 16'h01FF);
    tick_i = 1'b1;
    for (int i = 0; i < 256; i++) step();
    tick_i = 1'b0; step();
    rd(A_COUNT, v); chk("R10 count 256", v, 256);
    chk("R10 low wrap flag", ovf_lo_flag_o, 1);
    chk("R10 high flag clear", ovf_hi_flag_o, 0);
    chk("R10 irq low enabled", ovf_irq_o, 1);
    wr(A_CTRL, 16'h0054); step();
    chk("R10 irq low disabled", ovf_irq_o, 0);
    wr(A_FLAGS, 16'h0080); step();
    chk("R12 write one clears", ovf_lo_flag_o, 0);
    tick_i = 1'b1;
    for (int i = 0; i < 65280; i++) step();
    tick_i = 1'b0; step();
    rd(A_COUNT, v); chk("R10 full wrap count", v, 0);
    chk("R10 high wrap flag", ovf_hi_flag_o, 1);
    chk("R10 irq high", ovf_irq_o, 1);
    wr(A_FLAGS, 16'h0000); step();
    chk("R12 write zero keeps", ovf_hi_flag_o, 1);
    wr(A_FLAGS, 16'h0100); step();
    chk("R12 clear only own bit hi", ovf_hi_flag_o, 0);
    chk("R12 clear only own bit lo", ovf_lo_flag_o, 1);

    // random toggle trials (R9, R7)
    wr(A_CTRL, 16'h0014); wr(A_TGLEN, 16'h0001);
    for (int it = 0; it < 8; it++) begin
      int cv, n;
      cv = 1 + int'($urandom % 30);
      n  = int'($urandom % 40);
      wr(A_CMP2, 16'(cv));
      pulse_clr();
      wr(A_FLAGS, 16'h01FF);
      p0 = port_o;
      ticks(n);
      step();
      chk("R9 random toggle parity", port_o, exp_toggle(p0, n, cv));
      chk("R7 random compare flag", cmp_flag_o[2], (n >= cv) ? 1 : 0);
    end

    summary();
    $finish;
  end
endmodule